// File: doc/BRIEF.md
# Vector Length Control Register Unit

This unit holds the two lengths that govern a vector loop: the current vector length and the maximum vector length. Each is stored in a six-bit field. A stored zero stands for the largest length, 64, so the range 1..64 fits in six bits. Software changes the state in three ways. The first is a register-form control write carrying a six-bit value. The second is an immediate-form write carrying a five-bit value. The third is a set-length operation: it takes a requested element count and the maximum length as operands and settles the current length at the smaller of the two.

The set-length operation may return zero. A loop can then be entered at its exit test, and a branch placed after the operation skips the body when no elements remain. The unit reports this zero state on a dedicated pin. It also reports whether predicated operations are permitted: predicate masks are as wide as the integer register, so a length greater than that width permits only unpredicated work.

Each strobe is a single-cycle command with no back-pressure; the unit accepts one command every cycle. The set-length result leaves through a registered output qualified by a one-cycle valid pulse. The result has no ready input, because the value stays on the pin until the next set-length operation.

Top module: `vlen_ctrl`

## Requirements
- R1: After reset, the current length and the maximum length both read 64, the zero flag is low, and the result valid output is low.
- R2: With the target select at 0, a register-form write sets the current length from a six-bit value. Codes 1..63 mean themselves and code 0 means 64. The value is lowered to the maximum length if it exceeds it, the zero flag is cleared, and the new value is visible on the cycle after the strobe.
- R3: With the target select at 1, a register-form write sets the maximum length, with code 0 meaning 64. If the current length is nonzero and larger than the new maximum, it is lowered to that maximum in the same update.
- R4: The immediate-form write zero-extends its five-bit value and then follows the same rules as R2 and R3 for the selected target. It reaches 1..31 directly, and 0 means 64.
- R5: A set-length strobe loads the maximum length from its six-bit operand (0 means 64) and sets the current length to the minimum of the request and that maximum. Both are visible one cycle after the strobe.
- R6: The set-length result output carries that minimum from the cycle after the strobe and holds it until the next set-length strobe. The valid output is high for exactly that one cycle.
- R7: A set-length operation that yields 0 shows the current length as 0 and raises the zero flag. A current-length write or a nonzero set-length clears the flag. A maximum-length write leaves the flag and the zero length unchanged.
- R8: The predicate-allowed output is high exactly when the current length (0 while zero) is not greater than the XLEN parameter.
- R9: When strobes coincide, the set-length operation wins over a register-form write, and a register-form write wins over an immediate-form write. The losing commands have no effect.
- R10: The current length never exceeds the maximum length, and the maximum length never reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register-form write strobe |
| csr_wdata | input | LEN_W | Register-form write value (0 means 2**LEN_W) |
| imm_we | input | 1 | Immediate-form write strobe |
| imm_val | input | IMM_W | Immediate-form write value, zero-extended |
| csr_target | input | 1 | Write target: 0 current length, 1 maximum length |
| setvl_go | input | 1 | Set-length strobe |
| setvl_req | input | REQ_W | Requested element count |
| setvl_mvl | input | LEN_W | Maximum length operand (0 means 2**LEN_W) |
| vl | output | LEN_W+1 | Current length, 0..64 |
| mvl | output | LEN_W+1 | Maximum length, 1..64 |
| setvl_res | output | LEN_W+1 | Registered result of the last set-length operation |
| setvl_valid | output | 1 | One-cycle pulse marking a fresh result |
| vl_zero | output | 1 | Current length is zero |
| pred_ok | output | 1 | Predicated operations permitted at the current length |

## Verification
The hardest state to reach is a zero length followed by a maximum-length write. That write must leave both the zero length and the flag untouched, and the clamp logic must not revive the stored field that still decodes to 64. The sweep reaches this state by running every set-length request, including 0, against every maximum operand. After each operation it issues register-form and immediate-form maximum writes, then later a current-length write to show that the flag clears. The predicate boundary sits at 64 under the default XLEN and can never be exceeded there. The bench therefore builds the unit with XLEN set to 32, so that lengths on both sides of the boundary are swept.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  typedef enum logic {
    TGT_VL  = 1'b0,
    TGT_MVL = 1'b1
  } vlen_tgt_e;
endpackage

// File: rtl/vlen_expand.sv
module vlen_expand #(
  parameter int W = 6
) (
  input  logic [W-1:0] code,
  output logic [W:0]   cnt
);
  // a zero code stands for the largest count, 2**W
  always_comb begin
    if (code == '0) cnt = {1'b1, {W{1'b0}}};
    else            cnt = {1'b0, code};
  end
endmodule

// File: rtl/vlen_setvl.sv
module vlen_setvl #(
  parameter int LEN_W = 6,
  parameter int REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [REQ_W-1:0] req,
  input  logic [LEN_W:0]   mvl_cnt,
  output logic [LEN_W:0]   min_cnt,
  output logic [LEN_W:0]   res_q,
  output logic             res_valid
);
  localparam int CW = (REQ_W > LEN_W + 1) ? REQ_W : LEN_W + 1;

  logic [CW-1:0] req_x, mvl_x;
  assign req_x = CW'(req);
  assign mvl_x = CW'(mvl_cnt);

  always_comb begin
    if (req_x > mvl_x) min_cnt = mvl_cnt;
    else               min_cnt = req_x[LEN_W:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= go;
      if (go) res_q <= min_cnt;
    end
  end

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> res_valid);
  // R5
  res_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (res_q <= $past(mvl_cnt)) && (CW'(res_q) <= $past(req_x)));
  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(res_q) && !res_valid);
endmodule

// File: rtl/vlen_state.sv
module vlen_state
  import vlen_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sv_go,
  input  logic [LEN_W:0] sv_vl_cnt,
  input  logic [LEN_W:0] sv_mvl_cnt,
  input  logic           wr_go,
  input  vlen_tgt_e      wr_tgt,
  input  logic [LEN_W:0] wr_cnt,
  output logic [LEN_W:0] vl_cnt,
  output logic [LEN_W:0] mvl_cnt,
  output logic           zero
);
  logic [LEN_W-1:0] vl_q, mvl_q;
  logic             zero_q;
  logic [LEN_W:0]   vl_full;

  vlen_expand #(.W(LEN_W)) u_vl_exp  (.code(vl_q),  .cnt(vl_full));
  vlen_expand #(.W(LEN_W)) u_mvl_exp (.code(mvl_q), .cnt(mvl_cnt));

  assign vl_cnt = zero_q ? '0 : vl_full;
  assign zero   = zero_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q   <= '0;
      mvl_q  <= '0;
      zero_q <= 1'b0;
    end else if (sv_go) begin
      mvl_q  <= sv_mvl_cnt[LEN_W-1:0];
      vl_q   <= sv_vl_cnt[LEN_W-1:0];
      zero_q <= (sv_vl_cnt == '0);
    end else if (wr_go) begin
      if (wr_tgt == TGT_VL) begin
        vl_q   <= (wr_cnt > mvl_cnt) ? mvl_q : wr_cnt[LEN_W-1:0];
        zero_q <= 1'b0;
      end else begin
        mvl_q <= wr_cnt[LEN_W-1:0];
        if (!zero_q && (vl_full > wr_cnt)) vl_q <= wr_cnt[LEN_W-1:0];
      end
    end
  end

  // R10
  vl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_cnt <= mvl_cnt);
  // R10
  mvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_cnt != '0);
  // R7
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sv_go && wr_go && wr_tgt == TGT_VL) |=> !zero);
  // R7
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sv_go && wr_go && wr_tgt == TGT_MVL && zero) |=> zero && vl_cnt == '0);
  // R3
  mvl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sv_go && wr_go && wr_tgt == TGT_MVL) |=> mvl_cnt == $past(wr_cnt));
endmodule

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int IMM_W = 5,
  parameter int REQ_W = 8,
  parameter int XLEN  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [LEN_W-1:0] csr_wdata,
  input  logic             imm_we,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             csr_target,
  input  logic             setvl_go,
  input  logic [REQ_W-1:0] setvl_req,
  input  logic [LEN_W-1:0] setvl_mvl,
  output logic [LEN_W:0]   vl,
  output logic [LEN_W:0]   mvl,
  output logic [LEN_W:0]   setvl_res,
  output logic             setvl_valid,
  output logic             vl_zero,
  output logic             pred_ok
);
  localparam int XW = (XLEN > 0) ? $clog2(XLEN + 1) + 1 : 1;
  localparam int CW = (XW > LEN_W + 1) ? XW : LEN_W + 1;

  logic [LEN_W-1:0] imm_ext, wr_code;
  logic [LEN_W:0]   wr_cnt, sv_mvl_cnt, sv_vl_cnt;
  logic             wr_go;

  generate
    if (LEN_W > IMM_W) begin : g_imm_pad
      assign imm_ext = {{(LEN_W - IMM_W){1'b0}}, imm_val};
    end else begin : g_imm_cut
      assign imm_ext = imm_val[LEN_W-1:0];
    end
  endgenerate

  // register form takes precedence over immediate form
  assign wr_code = csr_we ? csr_wdata : imm_ext;
  assign wr_go   = csr_we | imm_we;

  vlen_expand #(.W(LEN_W)) u_wr_exp (.code(wr_code),   .cnt(wr_cnt));
  vlen_expand #(.W(LEN_W)) u_sv_exp (.code(setvl_mvl), .cnt(sv_mvl_cnt));

  vlen_setvl #(.LEN_W(LEN_W), .REQ_W(REQ_W)) u_setvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (setvl_go),
    .req       (setvl_req),
    .mvl_cnt   (sv_mvl_cnt),
    .min_cnt   (sv_vl_cnt),
    .res_q     (setvl_res),
    .res_valid (setvl_valid)
  );

  vlen_state #(.LEN_W(LEN_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .sv_go      (setvl_go),
    .sv_vl_cnt  (sv_vl_cnt),
    .sv_mvl_cnt (sv_mvl_cnt),
    .wr_go      (wr_go),
    .wr_tgt     (vlen_tgt_e'(csr_target)),
    .wr_cnt     (wr_cnt),
    .vl_cnt     (vl),
    .mvl_cnt    (mvl),
    .zero       (vl_zero)
  );

  assign pred_ok = (CW'(vl) <= CW'(XLEN));

  // R8
  pred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_zero |-> pred_ok);
  // R9
  setvl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setvl_go |=> mvl == $past(sv_mvl_cnt) && setvl_res == vl);
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl_zero |-> vl == '0);
endmodule

// File: tb/test_vlen_ctrl.sv
module test_vlen_ctrl;
  localparam int LW = 6;
  localparam int XL = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_we = 1'b0, imm_we = 1'b0, csr_target = 1'b0, setvl_go = 1'b0;
  logic [5:0] csr_wdata = '0, setvl_mvl = '0;
  logic [4:0] imm_val = '0;
  logic [7:0] setvl_req = '0;
  logic [6:0] vl, mvl, setvl_res;
  logic       setvl_valid, vl_zero, pred_ok;

  int n_chk = 0, n_bad = 0;
  int e_vl, e_mvl, e_res;
  bit e_zero, e_valid;

  always #2.5 clk = ~clk;

  vlen_ctrl #(.LEN_W(LW), .IMM_W(5), .REQ_W(8), .XLEN(XL)) i_vlen_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .imm_we(imm_we), .imm_val(imm_val), .csr_target(csr_target),
    .setvl_go(setvl_go), .setvl_req(setvl_req), .setvl_mvl(setvl_mvl),
    .vl(vl), .mvl(mvl), .setvl_res(setvl_res), .setvl_valid(setvl_valid),
    .vl_zero(vl_zero), .pred_ok(pred_ok)
  );

  function automatic int dec(int c);
    return (c == 0) ? 64 : c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " vl"}, int'(vl), e_zero ? 0 : e_vl);
    chk({req, " mvl"}, int'(mvl), e_mvl);
    chk({req, " zero R7"}, int'(vl_zero), int'(e_zero));
    chk({req, " valid R6"}, int'(setvl_valid), int'(e_valid));
    chk({req, " res R6"}, int'(setvl_res), e_res);
    chk({req, " pred R8"}, int'(pred_ok), int'((e_zero ? 0 : e_vl) <= XL));
  endtask

  task automatic model_write(int tgt, int code);
    int v = dec(code);
    if (tgt == 0) begin
      e_vl = (v > e_mvl) ? e_mvl : v;
      e_zero = 0;
    end else begin
      e_mvl = v;
      if (!e_zero && e_vl > v) e_vl = v;
    end
  endtask

  // strobes are driven after a falling edge and checked at the next falling edge
  task automatic do_csr(int tgt, int code, string req);
    csr_target = tgt[0]; csr_wdata = code[5:0]; csr_we = 1'b1;
    model_write(tgt, code); e_valid = 0;
    @(negedge clk); csr_we = 1'b0;
    check_all(req);
  endtask

  task automatic do_imm(int tgt, int code, string req);
    csr_target = tgt[0]; imm_val = code[4:0]; imm_we = 1'b1;
    model_write(tgt, code); e_valid = 0;
    @(negedge clk); imm_we = 1'b0;
    check_all(req);
  endtask

  task automatic do_setvl(int r, int f, string req);
    int m = dec(f);
    setvl_req = r[7:0]; setvl_mvl = f[5:0]; setvl_go = 1'b1;
    e_mvl = m; e_vl = (r > m) ? m : r; e_zero = (e_vl == 0);
    if (e_zero) e_vl = 0;
    e_res = e_vl; e_valid = 1;
    @(negedge clk); setvl_go = 1'b0;
    check_all(req);
  endtask

  initial begin
    e_vl = 64; e_mvl = 64; e_zero = 0; e_valid = 0; e_res = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2 / R3: register-form sweep over every maximum and every length code
    for (int mc = 0; mc < 64; mc++) begin
      do_csr(1, mc, "R3 mvl write");
      for (int vc = 0; vc < 64; vc++) do_csr(0, vc, "R2 vl write");
      do_csr(1, (mc * 7 + 3) % 64, "R3 mvl shrink");
    end

    // R4: immediate-form sweep
    for (int mc = 0; mc < 32; mc++) begin
      do_imm(1, mc, "R4 imm mvl");
      for (int vc = 0; vc < 32; vc++) do_imm(0, vc, "R4 imm vl");
    end

    // R5 / R6 / R7: set-length sweep, with a maximum write after each result
    for (int f = 0; f < 64; f++) begin
      for (int r = 0; r < 70; r++) begin
        do_setvl(r, f, "R5 setvl");
        if (r % 5 == 0) do_csr(1, (r + f) % 64, "R7 mvl after setvl");
        if (r % 9 == 0) do_imm(1, (r + 2 * f) % 32, "R7 imm mvl after setvl");
      end
      e_valid = 0;
      @(negedge clk);
      check_all("R6 valid drops");
    end
    do_setvl(255, 20, "R5 large request");
    do_setvl(0, 0, "R7 zero result");
    do_csr(1, 10, "R7 zero kept over mvl write");
    do_csr(0, 5, "R7 zero cleared by vl write");

    // R9: coincident strobes
    do_setvl(0, 40, "R9 setup");
    csr_we = 1'b1; imm_we = 1'b1; setvl_go = 1'b1; csr_target = 1'b1;
    csr_wdata = 6'd3; imm_val = 5'd7; setvl_req = 8'd12; setvl_mvl = 6'd30;
    e_mvl = 30; e_vl = 12; e_zero = 0; e_res = 12; e_valid = 1;
    @(negedge clk); setvl_go = 1'b0;
    check_all("R9 setvl wins");
    csr_target = 1'b0; csr_wdata = 6'd9; imm_val = 5'd4;
    e_vl = 9; e_valid = 0;
    @(negedge clk); csr_we = 1'b0;
    check_all("R9 reg form wins");
    imm_we = 1'b0;
    @(negedge clk);
    check_all("R9 idle");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule